// File: doc/BRIEF.md
# Two's Complement Add/Subtract Unit with Condition Codes

This block adds or subtracts two W-bit two's complement operands in one combinational pass. A single operation input picks addition or subtraction. Subtraction uses the same adder as addition: the operation bit inverts every bit of B and is also fed in as the adder carry-in, so the adder forms A + ~B + 1.

Beside the W-bit result, the unit drives four condition codes: zero, negative, carry and overflow. From those four flags it derives a full set of signed and unsigned magnitude predicates. The predicates are meaningful after a subtraction, where they report how A compares with B. A compare is therefore a subtraction whose result is discarded.

The carry network has two variants, chosen by a parameter: a bitwise ripple chain, or a logarithmic-depth parallel-prefix tree built from generate and propagate terms. Both variants produce identical outputs.

Top module: `addsub_flags`

## Requirements
- R1: With sub_i = 0, res_o equals (a_i + b_i) modulo 2^W.
- R2: With sub_i = 1, res_o equals (a_i - b_i) modulo 2^W, formed as a_i + ~b_i + 1.
- R3: zero_o is 1 exactly when every bit of res_o is 0.
- R4: neg_o equals res_o[W-1].
- R5: carry_o is the carry out of the top adder bit. For addition it is 1 when a_i + b_i >= 2^W as unsigned values. For subtraction it is 1 when a_i >= b_i as unsigned values, which means no borrow.
- R6: ovf_o is 1 exactly when the signed result of the selected operation lies outside [-2^(W-1), 2^(W-1)-1].
- R7: With sub_i = 1, the signed predicates lt_o, le_o, ge_o and gt_o equal the signed comparisons A<B, A<=B, A>=B and A>B. They are formed as lt = N^V, le = Z|(N^V), ge = ~(N^V) and gt = ~(Z|(N^V)).
- R8: With sub_i = 1, eq_o equals (a_i == b_i) and ne_o is its complement.
- R9: With sub_i = 1, the unsigned predicates ltu_o, leu_o, geu_o and gtu_o equal the unsigned comparisons A<B, A<=B, A>=B and A>B. They are formed as ltu = ~C, leu = ~C|Z, geu = C and gtu = C&~Z.
- R10: Both carry styles give identical values on every output for identical inputs. CARRY_STYLE = CARRY_RIPPLE (0) selects the ripple chain and CARRY_STYLE = CARRY_PREFIX (1) selects the prefix tree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| sub_i | input | 1 | 0 = add, 1 = subtract (A - B) |
| res_o | output | W | Result modulo 2^W |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result MSB |
| carry_o | output | 1 | Carry out of top bit |
| ovf_o | output | 1 | Signed overflow |
| lt_o | output | 1 | Signed less than |
| le_o | output | 1 | Signed less or equal |
| eq_o | output | 1 | Equal |
| ne_o | output | 1 | Not equal |
| ge_o | output | 1 | Signed greater or equal |
| gt_o | output | 1 | Signed greater than |
| ltu_o | output | 1 | Unsigned less than |
| leu_o | output | 1 | Unsigned less or equal |
| geu_o | output | 1 | Unsigned greater or equal |
| gtu_o | output | 1 | Unsigned greater than |

## Verification
At W = 4, every operand pair is applied in both operations. This proves the flag equations and all ten predicates over the whole input space, including the pairs where overflow makes N alone give the wrong signed answer.

At W = 8, fixed corner pairs are applied first. They cover the most positive value plus one, the most negative value minus one, all-ones plus one, subtraction of the most negative value, and equal operands. These separate the carry, overflow and zero paths from one another. Random pairs then follow, and they also drive a ripple instance and a prefix instance side by side. Any difference between the two instances exposes a fault in one of the carry networks.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    CARRY_RIPPLE = 1'b0,
    CARRY_PREFIX = 1'b1
  } carry_style_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } cond_t;
endpackage

// File: rtl/addsub_operand.sv
module addsub_operand #(
  parameter int W = 8
) (
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] b_eff_o,
  output logic         cin_o
);
  // one control bit drives both the inversion and the +1
  assign b_eff_o = b_i ^ {W{sub_i}};
  assign cin_o   = sub_i;
endmodule

// File: rtl/addsub_adder.sv
module addsub_adder
  import addsub_pkg::*;
#(
  parameter int           W           = 8,
  parameter carry_style_e CARRY_STYLE = CARRY_RIPPLE
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int LV = (W > 1) ? $clog2(W) : 0;

  logic [W-1:0] p, g;
  logic [W:0]   c;

  assign p    = a_i ^ b_i;
  assign g    = a_i & b_i;
  assign c[0] = cin_i;

  if (CARRY_STYLE == CARRY_RIPPLE) begin : g_ripple
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign c[i+1] = g[i] | (p[i] & c[i]);
    end
  end else begin : g_prefix
    // gg/pp[l][i]: group terms over bits max(0,i-2^l+1)..i
    logic [W-1:0] gg [LV+1];
    logic [W-1:0] pp [LV+1];
    assign gg[0] = g;
    assign pp[0] = p;
    for (genvar l = 0; l < LV; l++) begin : g_lvl
      localparam int D = 1 << l;
      for (genvar i = 0; i < W; i++) begin : g_node
        if (i >= D) begin : g_merge
          assign gg[l+1][i] = gg[l][i] | (pp[l][i] & gg[l][i-D]);
          assign pp[l+1][i] = pp[l][i] & pp[l][i-D];
        end else begin : g_pass
          assign gg[l+1][i] = gg[l][i];
          assign pp[l+1][i] = pp[l][i];
        end
      end
    end
    for (genvar i = 0; i < W; i++) begin : g_carry
      assign c[i+1] = gg[LV][i] | (pp[LV][i] & cin_i);
    end
  end

  assign sum_o  = p ^ c[W-1:0];
  assign cout_o = c[W];
endmodule

// File: rtl/addsub_cond.sv
module addsub_cond
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  input  logic [W-1:0] sum_i,
  input  logic         cout_i,
  output cond_t        cc_o
);
  logic s_msb;
  assign s_msb = sum_i[W-1];

  assign cc_o.z = ~|sum_i;
  assign cc_o.n = s_msb;
  assign cc_o.c = cout_i;
  // inputs here are post-inversion adder inputs
  assign cc_o.v = (a_msb_i & b_msb_i & ~s_msb) | (~a_msb_i & ~b_msb_i & s_msb);
endmodule

// File: rtl/addsub_compare.sv
module addsub_compare
  import addsub_pkg::*;
(
  input  cond_t cc_i,
  output logic  lt_o,
  output logic  le_o,
  output logic  eq_o,
  output logic  ne_o,
  output logic  ge_o,
  output logic  gt_o,
  output logic  ltu_o,
  output logic  leu_o,
  output logic  geu_o,
  output logic  gtu_o
);
  logic n_x_v;
  assign n_x_v = cc_i.n ^ cc_i.v;

  assign lt_o  = n_x_v;
  assign le_o  = cc_i.z | n_x_v;
  assign ge_o  = ~n_x_v;
  assign gt_o  = ~(cc_i.z | n_x_v);
  assign eq_o  = cc_i.z;
  assign ne_o  = ~cc_i.z;
  // C set means no borrow
  assign ltu_o = ~cc_i.c;
  assign leu_o = ~cc_i.c | cc_i.z;
  assign geu_o = cc_i.c;
  assign gtu_o = cc_i.c & ~cc_i.z;
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int           W           = 8,
  parameter carry_style_e CARRY_STYLE = CARRY_RIPPLE
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         lt_o,
  output logic         le_o,
  output logic         eq_o,
  output logic         ne_o,
  output logic         ge_o,
  output logic         gt_o,
  output logic         ltu_o,
  output logic         leu_o,
  output logic         geu_o,
  output logic         gtu_o
);
  logic [W-1:0] b_eff, sum;
  logic         cin, cout;
  cond_t        cc;

  addsub_operand #(.W(W)) u_operand (
    .b_i     (b_i),
    .sub_i   (sub_i),
    .b_eff_o (b_eff),
    .cin_o   (cin)
  );

  addsub_adder #(.W(W), .CARRY_STYLE(CARRY_STYLE)) u_adder (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  addsub_cond #(.W(W)) u_cond (
    .a_msb_i (a_i[W-1]),
    .b_msb_i (b_eff[W-1]),
    .sum_i   (sum),
    .cout_i  (cout),
    .cc_o    (cc)
  );

  addsub_compare u_compare (
    .cc_i  (cc),
    .lt_o  (lt_o),
    .le_o  (le_o),
    .eq_o  (eq_o),
    .ne_o  (ne_o),
    .ge_o  (ge_o),
    .gt_o  (gt_o),
    .ltu_o (ltu_o),
    .leu_o (leu_o),
    .geu_o (geu_o),
    .gtu_o (gtu_o)
  );

  assign res_o   = sum;
  assign zero_o  = cc.z;
  assign neg_o   = cc.n;
  assign carry_o = cc.c;
  assign ovf_o   = cc.v;
endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         sub_i,
  input logic [W-1:0] res_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         lt_o,
  input logic         eq_o,
  input logic         ltu_o
);
  logic [W-1:0] diff, add;
  assign diff = a_i - b_i;
  assign add  = a_i + b_i;

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i})) begin
      // R1
      add_value_chk: assert (sub_i || res_o == add);
      // R2
      sub_value_chk: assert (!sub_i || res_o == diff);
      // R3
      zero_flag_chk: assert (zero_o == (res_o == '0));
      // R4
      neg_flag_chk: assert (neg_o == res_o[W-1]);
      // R5
      borrow_chk: assert (!sub_i || carry_o == (a_i >= b_i));
      // R6
      sub_overflow_chk: assert (!sub_i ||
        ovf_o == ((a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1])));
      // R7
      signed_lt_chk: assert (!sub_i || lt_o == ($signed(a_i) < $signed(b_i)));
      // R8
      equal_chk: assert (!sub_i || eq_o == (a_i == b_i));
      // R9
      unsigned_lt_chk: assert (!sub_i || ltu_o == (a_i < b_i));
    end
  end
endmodule

bind addsub_flags addsub_flags_chk #(.W(W)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .sub_i   (sub_i),
  .res_o   (res_o),
  .zero_o  (zero_o),
  .neg_o   (neg_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o),
  .lt_o    (lt_o),
  .eq_o    (eq_o),
  .ltu_o   (ltu_o)
);

// File: tb/addsub_flags_tb.sv
`timescale 1ns/1ps
module addsub_flags_tb;
  import addsub_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  logic [7:0] a8 = '0, b8 = '0;
  logic       s8 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       s4 = 1'b0;

  logic [7:0] r8, rp8;
  logic [3:0] r4;
  logic [13:0] f8, fp8, f4;

  addsub_flags #(.W(8)) u_dut (
    .a_i(a8), .b_i(b8), .sub_i(s8), .res_o(r8),
    .zero_o(f8[13]), .neg_o(f8[12]), .carry_o(f8[11]), .ovf_o(f8[10]),
    .lt_o(f8[9]), .le_o(f8[8]), .eq_o(f8[7]), .ne_o(f8[6]),
    .ge_o(f8[5]), .gt_o(f8[4]), .ltu_o(f8[3]), .leu_o(f8[2]),
    .geu_o(f8[1]), .gtu_o(f8[0])
  );

  addsub_flags #(.W(8), .CARRY_STYLE(CARRY_PREFIX)) u_dut_pf8 (
    .a_i(a8), .b_i(b8), .sub_i(s8), .res_o(rp8),
    .zero_o(fp8[13]), .neg_o(fp8[12]), .carry_o(fp8[11]), .ovf_o(fp8[10]),
    .lt_o(fp8[9]), .le_o(fp8[8]), .eq_o(fp8[7]), .ne_o(fp8[6]),
    .ge_o(fp8[5]), .gt_o(fp8[4]), .ltu_o(fp8[3]), .leu_o(fp8[2]),
    .geu_o(fp8[1]), .gtu_o(fp8[0])
  );

  addsub_flags #(.W(4), .CARRY_STYLE(CARRY_PREFIX)) u_dut4 (
    .a_i(a4), .b_i(b4), .sub_i(s4), .res_o(r4),
    .zero_o(f4[13]), .neg_o(f4[12]), .carry_o(f4[11]), .ovf_o(f4[10]),
    .lt_o(f4[9]), .le_o(f4[8]), .eq_o(f4[7]), .ne_o(f4[6]),
    .ge_o(f4[5]), .gt_o(f4[4]), .ltu_o(f4[3]), .leu_o(f4[2]),
    .geu_o(f4[1]), .gtu_o(f4[0])
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference from integer arithmetic
  task automatic check_vec(input int w, input int ua, input int ub, input bit sub,
                           input int res, input logic [13:0] fl);
    int mask, half, sum, sa, sb, tr, er;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    sa = (ua >= half) ? ua - (1 << w) : ua;
    sb = (ub >= half) ? ub - (1 << w) : ub;
    tr = sub ? sa - sb : sa + sb;
    sum = sub ? ua + ((~ub) & mask) + 1 : ua + ub;
    er = sum & mask;
    chk(sub ? "R2" : "R1", "res", res, er);
    chk("R3", "zero", int'(fl[13]), int'(er == 0));
    chk("R4", "neg", int'(fl[12]), int'(er >= half));
    chk("R5", "carry", int'(fl[11]), sub ? int'(ua >= ub) : int'(ua + ub > mask));
    chk("R6", "ovf", int'(fl[10]), int'(tr < -half || tr > half - 1));
    if (sub) begin
      chk("R7", "lt", int'(fl[9]), int'(sa < sb));
      chk("R7", "le", int'(fl[8]), int'(sa <= sb));
      chk("R7", "ge", int'(fl[5]), int'(sa >= sb));
      chk("R7", "gt", int'(fl[4]), int'(sa > sb));
      chk("R8", "eq", int'(fl[7]), int'(ua == ub));
      chk("R8", "ne", int'(fl[6]), int'(ua != ub));
      chk("R9", "ltu", int'(fl[3]), int'(ua < ub));
      chk("R9", "leu", int'(fl[2]), int'(ua <= ub));
      chk("R9", "geu", int'(fl[1]), int'(ua >= ub));
      chk("R9", "gtu", int'(fl[0]), int'(ua > ub));
    end
  endtask

  task automatic apply(input logic [7:0] na8, input logic [7:0] nb8, input bit ns8,
                       input logic [3:0] na4, input logic [3:0] nb4, input bit ns4);
    @(posedge clk);
    #0.5;
    a8 = na8; b8 = nb8; s8 = ns8;
    a4 = na4; b4 = nb4; s4 = ns4;
    @(negedge clk);
    check_vec(8, int'(a8), int'(b8), s8, int'(r8), f8);
    check_vec(4, int'(a4), int'(b4), s4, int'(r4), f4);
    // R10 ripple vs prefix
    chk("R10", "res_style", int'(rp8), int'(r8));
    chk("R10", "flags_style", int'(fp8), int'(f8));
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // initial state: all zero operands, add
    @(negedge clk);
    chk("R3", "zero_at_start", int'(f8[13]), 1);
    chk("R1", "res_at_start", int'(r8), 0);
    // W=8 corners, W=4 exhaustive alongside
    apply(8'h7f, 8'h01, 1'b0, 4'h0, 4'h0, 1'b0);
    apply(8'h80, 8'h01, 1'b1, 4'h7, 4'h7, 1'b0);
    apply(8'hff, 8'h01, 1'b0, 4'hf, 4'h1, 1'b0);
    apply(8'h80, 8'h80, 1'b1, 4'h8, 4'h1, 1'b1);
    apply(8'h00, 8'h80, 1'b1, 4'h0, 4'h8, 1'b1);
    apply(8'h5a, 8'h5a, 1'b1, 4'h3, 4'h3, 1'b1);
    apply(8'h80, 8'hff, 1'b0, 4'h8, 4'h8, 1'b0);
    apply(8'h01, 8'hff, 1'b1, 4'h1, 4'hf, 1'b1);
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply(8'($urandom), 8'($urandom), 1'($urandom), 4'(a), 4'(b), 1'(s));
    for (int k = 0; k < 2000; k++)
      apply(8'($urandom), 8'($urandom), 1'($urandom),
            4'($urandom), 4'($urandom), 1'($urandom));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end
endmodule